// File: doc/BRIEF.md
# Pipelined Nonvolatile Memory Command Controller

This block sits in front of a nonvolatile memory array and takes commands from a host bus. Each command is a 3-bit code, an address and a data word. A two-entry queue holds them. The front entry takes the host write. The second entry is the execution register inside the sequencer. Because of this, the host can load the next command while the current one is still running. A programmable divider turns the system clock into a timebase tick, and a small sequencer times each array operation in those ticks. The array and its charge pumps are stood in for by duration counters and a high-voltage enable output.

The sequencer has three states:
- `S_IDLE`: nothing is executing.
- `S_RAMP`: the high-voltage supply is coming up, for program and erase only.
- `S_RUN`: the operation itself.

The transitions are:
- IDLE→RAMP: a queued program or erase is loaded.
- IDLE→RUN: a queued verify or compress is loaded. These need no high voltage.
- RAMP→RUN: the ramp count ends.
- RUN→IDLE: the operation count ends.
- RUN→RUN: a program ends and the queued command is a program to the same row. The next command loads with no ramp, and high voltage stays on.
- RAMP→IDLE and RUN→IDLE on an abort tick: an erase abort ends a running erase.

Two live flags report the block's state. Buffer-empty shows that the front entry is free. Command-complete shows that nothing is queued or running. Each flag drives an interrupt behind its own enable bit. Two sticky flags record an access error and a partially erased array. Writing a one to a sticky flag's bit clears it.

Top module: `nvm_cmd_ctrl`

## Requirements
- R1: After reset, or on reset during an operation:
  - both queue entries are empty;
  - `hv_on` is 0;
  - `buf_empty` and `cmd_done` are 1;
  - `acc_err`, `part_erased`, the interrupt outputs and `run_code` are 0;
  - the divider counts as unwritten.
- R2: Until `div_we` has written the divider at least once, every command write sets `acc_err` and is discarded. `buf_empty` stays 1 and nothing executes.
- R3: The command codes are: 1 program, 2 erase, 3 erase verify, 4 erase abort, 5 data compress. A write of any other code (0, 6, 7) sets `acc_err` and is dropped.
- R4: A command written while `buf_empty` is 1 is held in the front entry, and `buf_empty` reads 0 until the sequencer takes it. A second command is accepted while the first executes.
- R5: A queued command written while the front entry is full sets `acc_err` and is dropped. The executing command continues unchanged.
- R6: Durations count timebase ticks. Program takes 20 ticks, erase takes 2000, and verify and compress take 50 each. Program and erase first spend 5 ticks in the ramp. With a divider of 0, `cmd_done` rises 1+5+20 clocks after the edge that accepts a lone program. For erase that is 1+5+2000 clocks, and for verify or compress it is 1+50 clocks.
- R7: With divider value D, the timebase ticks once every D+1 clocks.
- R8: `cmd_done` is 1 exactly when no command is executing and none is queued.
- R9: `irq_empty` equals `buf_empty` AND enable bit 0. `irq_done` equals `cmd_done` AND enable bit 1. The enables are written through `ien_we`/`ien_val`.
- R10: `hv_on` is 1 during the ramp and run of program and erase. It is 0 during verify, during compress and while idle. Between two programs to different rows it drops for at least one clock.
- R11: When a program ends and the queued command is a program whose address matches in bits [AW-1:ROW_LSB] (row), the next program starts at once with no ramp, and `hv_on` stays 1 throughout.
- R12: Erase abort (code 4) is never queued and ignores the full check.
  - While an erase is executing, it empties the front entry at once, ends the erase at the next tick and sets `part_erased`.
  - With no erase executing, it has no effect.
- R13: Writing `clr_val` with bit 0 set clears `acc_err`. Writing it with bit 1 set clears `part_erased`.
- R14: While a command executes, `run_code`, `run_addr` and `run_data` show its code, address and data. While idle, `run_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_we | input | 1 | Divider write strobe |
| div_val | input | DIV_W | Divider value; tick period is value+1 clocks |
| cmd_we | input | 1 | Command write strobe |
| cmd_code | input | 3 | Command code |
| cmd_addr | input | AW | Command address |
| cmd_data | input | DW | Command data word |
| ien_we | input | 1 | Interrupt enable write strobe |
| ien_val | input | 2 | Bit 0 enables the buffer-empty interrupt, bit 1 the complete interrupt |
| clr_we | input | 1 | Sticky flag clear strobe |
| clr_val | input | 2 | Bit 0 clears the access error, bit 1 the partial-erase flag |
| buf_empty | output | 1 | Front queue entry is free |
| cmd_done | output | 1 | Nothing executing or queued |
| acc_err | output | 1 | Sticky access error |
| part_erased | output | 1 | Sticky partial-erase flag |
| irq_empty | output | 1 | Buffer-empty interrupt |
| irq_done | output | 1 | Command-complete interrupt |
| hv_on | output | 1 | High-voltage enable |
| run_code | output | 3 | Code of the executing command |
| run_addr | output | AW | Address of the executing command |
| run_data | output | DW | Data of the executing command |

## Verification
The hardest case to reach is the same-row handoff. The queued program must already sit in the front entry on the exact tick the first program ends. The bench loads the second program one clock after the sequencer takes the first. It then samples `hv_on` on every clock until `cmd_done` rises, and the total clock count shows whether the ramp was skipped. An abort racing a queued command is reached in a similar way. An erase is started and a verify is queued behind it. The abort then arrives mid-erase, and the bench watches long enough to see that the verify never runs.

// File: rtl/nvm_cmd_pkg.sv
package nvm_cmd_pkg;

    localparam logic [2:0] OP_PROG     = 3'd1;
    localparam logic [2:0] OP_ERASE    = 3'd2;
    localparam logic [2:0] OP_VERIFY   = 3'd3;
    localparam logic [2:0] OP_ABORT    = 3'd4;
    localparam logic [2:0] OP_COMPRESS = 3'd5;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RAMP = 2'd1,
        S_RUN  = 2'd2
    } seq_state_e;

    // codes that travel through the queue
    function automatic logic code_queued(input logic [2:0] c);
        return (c == OP_PROG) || (c == OP_ERASE) ||
               (c == OP_VERIFY) || (c == OP_COMPRESS);
    endfunction

    function automatic logic code_needs_hv(input logic [2:0] c);
        return (c == OP_PROG) || (c == OP_ERASE);
    endfunction

endpackage

// File: rtl/nvm_tick_gen.sv
module nvm_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_val,
    output logic             div_ok,
    output logic             tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            cnt_q  <= '0;
            div_ok <= 1'b0;
        end else if (div_we) begin
            div_q  <= div_val;
            cnt_q  <= '0;
            div_ok <= 1'b1;
        end else if (div_ok) begin
            cnt_q <= (cnt_q == div_q) ? '0 : cnt_q + 1'b1;
        end
    end

    assign tick = div_ok && !div_we && (cnt_q == div_q);

    // R7
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_q != '0) |=> !tick);

endmodule

// File: rtl/nvm_cmd_queue.sv
module nvm_cmd_queue
    import nvm_cmd_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          div_ok,
    input  logic          cmd_we,
    input  logic [2:0]    cmd_code,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic          erase_running,
    input  logic          pop,
    input  logic          clr_err,
    output logic          front_valid,
    output logic [2:0]    front_code,
    output logic [AW-1:0] front_addr,
    output logic [DW-1:0] front_data,
    output logic          abort_set,
    output logic          err_q
);
    logic is_abort;
    logic push;
    logic reject;

    always_comb begin
        is_abort  = (cmd_code == OP_ABORT);
        push      = cmd_we && div_ok && code_queued(cmd_code) && !front_valid;
        abort_set = cmd_we && div_ok && is_abort && erase_running;
        reject    = cmd_we && (!div_ok ||
                    (!is_abort && (!code_queued(cmd_code) || front_valid)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            front_valid <= 1'b0;
            front_code  <= '0;
            front_addr  <= '0;
            front_data  <= '0;
            err_q       <= 1'b0;
        end else begin
            if (push) begin
                front_valid <= 1'b1;
                front_code  <= cmd_code;
                front_addr  <= cmd_addr;
                front_data  <= cmd_data;
            end else if (pop || abort_set) begin
                front_valid <= 1'b0;
            end
            if (reject) begin
                err_q <= 1'b1;
            end else if (clr_err) begin
                err_q <= 1'b0;
            end
        end
    end

    // R5
    front_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (front_valid && !pop && !abort_set) |=>
            (front_valid && $stable(front_code) && $stable(front_addr)));
    // R2
    no_div_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !div_ok |-> !front_valid);
    // R4
    pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> front_valid);

endmodule

// File: rtl/nvm_op_seq.sv
module nvm_op_seq
    import nvm_cmd_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 16,
    parameter int ROW_LSB = 4,
    parameter int T_PROG  = 20,
    parameter int T_ERASE = 2000,
    parameter int T_VER   = 50,
    parameter int T_COMP  = 50,
    parameter int T_RAMP  = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          front_valid,
    input  logic [2:0]    front_code,
    input  logic [AW-1:0] front_addr,
    input  logic [DW-1:0] front_data,
    input  logic          abort_set,
    input  logic          clr_part,
    output logic          pop,
    output logic          busy,
    output logic          erase_running,
    output logic          hv_on,
    output logic          part_erased,
    output logic [2:0]    run_code,
    output logic [AW-1:0] run_addr,
    output logic [DW-1:0] run_data
);
    localparam int T_MAX1 = (T_PROG > T_ERASE) ? T_PROG : T_ERASE;
    localparam int T_MAX2 = (T_VER > T_COMP) ? T_VER : T_COMP;
    localparam int T_MAX3 = (T_MAX1 > T_MAX2) ? T_MAX1 : T_MAX2;
    localparam int T_MAX  = (T_MAX3 > T_RAMP) ? T_MAX3 : T_RAMP;
    localparam int CNT_W  = $clog2(T_MAX + 1);

    seq_state_e       state, nxt;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_m1;
    logic [2:0]       exec_code;
    logic [AW-1:0]    exec_addr;
    logic [DW-1:0]    exec_data;
    logic             abort_q;
    logic             load;
    logic             ramp_end;
    logic             run_end;
    logic             abort_fire;
    logic             chain;

    always_comb begin
        unique case (exec_code)
            OP_PROG:   len_m1 = CNT_W'(T_PROG - 1);
            OP_ERASE:  len_m1 = CNT_W'(T_ERASE - 1);
            OP_VERIFY: len_m1 = CNT_W'(T_VER - 1);
            default:   len_m1 = CNT_W'(T_COMP - 1);
        endcase
        ramp_end   = tick && (cnt_q == CNT_W'(T_RAMP - 1));
        run_end    = tick && (cnt_q == len_m1);
        abort_fire = abort_q && tick;
        chain      = (exec_code == OP_PROG) && front_valid &&
                     (front_code == OP_PROG) &&
                     (front_addr[AW-1:ROW_LSB] == exec_addr[AW-1:ROW_LSB]);
    end

    // next state and load decision
    always_comb begin
        nxt  = state;
        load = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (front_valid) begin
                    load = 1'b1;
                    nxt  = code_needs_hv(front_code) ? S_RAMP : S_RUN;
                end
            end
            S_RAMP: begin
                if (abort_fire)    nxt = S_IDLE;
                else if (ramp_end) nxt = S_RUN;
            end
            S_RUN: begin
                if (abort_fire) begin
                    nxt = S_IDLE;
                end else if (run_end) begin
                    if (chain) load = 1'b1;
                    else       nxt  = S_IDLE;
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    // state register and its companions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cnt_q     <= '0;
            exec_code <= '0;
            exec_addr <= '0;
            exec_data <= '0;
            abort_q   <= 1'b0;
            part_erased <= 1'b0;
        end else begin
            state <= nxt;
            if (load || nxt != state) cnt_q <= '0;
            else if (tick)            cnt_q <= cnt_q + 1'b1;
            if (load) begin
                exec_code <= front_code;
                exec_addr <= front_addr;
                exec_data <= front_data;
            end
            if (nxt == S_IDLE) abort_q <= 1'b0;
            else if (abort_set) abort_q <= 1'b1;
            if (abort_fire && state != S_IDLE) part_erased <= 1'b1;
            else if (clr_part)                 part_erased <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        pop           = load;
        busy          = (state != S_IDLE);
        erase_running = busy && (exec_code == OP_ERASE);
        hv_on         = (state == S_RAMP) ||
                        ((state == S_RUN) && code_needs_hv(exec_code));
        run_code      = busy ? exec_code : 3'd0;
        run_addr      = exec_addr;
        run_data      = exec_data;
    end

    // R11
    chain_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && load) |=> (state == S_RUN && hv_on));
    // R12
    abort_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && abort_fire) |=> (state == S_IDLE && part_erased));

endmodule

// File: rtl/nvm_cmd_ctrl.sv
module nvm_cmd_ctrl
    import nvm_cmd_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int AW      = 16,
    parameter int DW      = 16,
    parameter int ROW_LSB = 4,
    parameter int T_PROG  = 20,
    parameter int T_ERASE = 2000,
    parameter int T_VER   = 50,
    parameter int T_COMP  = 50,
    parameter int T_RAMP  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_val,
    input  logic             cmd_we,
    input  logic [2:0]       cmd_code,
    input  logic [AW-1:0]    cmd_addr,
    input  logic [DW-1:0]    cmd_data,
    input  logic             ien_we,
    input  logic [1:0]       ien_val,
    input  logic             clr_we,
    input  logic [1:0]       clr_val,
    output logic             buf_empty,
    output logic             cmd_done,
    output logic             acc_err,
    output logic             part_erased,
    output logic             irq_empty,
    output logic             irq_done,
    output logic             hv_on,
    output logic [2:0]       run_code,
    output logic [AW-1:0]    run_addr,
    output logic [DW-1:0]    run_data
);
    logic          div_ok, tick;
    logic          front_valid, abort_set, pop, busy, erase_running;
    logic [2:0]    front_code;
    logic [AW-1:0] front_addr;
    logic [DW-1:0] front_data;
    logic [1:0]    ien_q;

    nvm_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .div_we(div_we), .div_val(div_val),
        .div_ok(div_ok), .tick(tick)
    );

    nvm_cmd_queue #(.AW(AW), .DW(DW)) u_queue (
        .clk(clk), .rst_n(rst_n), .div_ok(div_ok),
        .cmd_we(cmd_we), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .erase_running(erase_running), .pop(pop),
        .clr_err(clr_we && clr_val[0]),
        .front_valid(front_valid), .front_code(front_code),
        .front_addr(front_addr), .front_data(front_data),
        .abort_set(abort_set), .err_q(acc_err)
    );

    nvm_op_seq #(
        .AW(AW), .DW(DW), .ROW_LSB(ROW_LSB), .T_PROG(T_PROG),
        .T_ERASE(T_ERASE), .T_VER(T_VER), .T_COMP(T_COMP), .T_RAMP(T_RAMP)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .front_valid(front_valid), .front_code(front_code),
        .front_addr(front_addr), .front_data(front_data),
        .abort_set(abort_set), .clr_part(clr_we && clr_val[1]),
        .pop(pop), .busy(busy), .erase_running(erase_running),
        .hv_on(hv_on), .part_erased(part_erased),
        .run_code(run_code), .run_addr(run_addr), .run_data(run_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (ien_we) ien_q <= ien_val;
    end

    always_comb begin
        buf_empty = !front_valid;
        cmd_done  = !front_valid && !busy;
        irq_empty = buf_empty && ien_q[0];
        irq_done  = cmd_done && ien_q[1];
    end

    // R8
    done_cold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> (!hv_on && run_code == 3'd0));

endmodule

// File: tb/tb_nvm_cmd_ctrl.sv
module tb_nvm_cmd_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        div_we;
    logic [7:0]  div_val;
    logic        cmd_we;
    logic [2:0]  cmd_code;
    logic [15:0] cmd_addr, cmd_data;
    logic        ien_we;
    logic [1:0]  ien_val;
    logic        clr_we;
    logic [1:0]  clr_val;
    logic        buf_empty, cmd_done, acc_err, part_erased;
    logic        irq_empty, irq_done, hv_on;
    logic [2:0]  run_code;
    logic [15:0] run_addr, run_data;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    nvm_cmd_ctrl dut (
        .clk(clk), .rst_n(rst_n), .div_we(div_we), .div_val(div_val),
        .cmd_we(cmd_we), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .ien_we(ien_we), .ien_val(ien_val),
        .clr_we(clr_we), .clr_val(clr_val), .buf_empty(buf_empty),
        .cmd_done(cmd_done), .acc_err(acc_err), .part_erased(part_erased),
        .irq_empty(irq_empty), .irq_done(irq_done), .hv_on(hv_on),
        .run_code(run_code), .run_addr(run_addr), .run_data(run_data)
    );

    // code, addr, data, clocks from accept edge to cmd_done (divider 0) - R6
    localparam int NV = 5;
    localparam logic [50:0] VEC [NV] = '{
        {3'd1, 16'h0100, 16'hA5A5, 16'd26},
        {3'd3, 16'h0200, 16'h0000, 16'd51},
        {3'd5, 16'h0300, 16'h1234, 16'd51},
        {3'd2, 16'h0400, 16'h0000, 16'd2006},
        {3'd1, 16'hFFF0, 16'h5A5A, 16'd26}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic put(input logic [2:0] c, input logic [15:0] a, input logic [15:0] d);
        cmd_we = 1'b1; cmd_code = c; cmd_addr = a; cmd_data = d;
        @(posedge clk);
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic set_div(input logic [7:0] v);
        div_we = 1'b1; div_val = v;
        step(1);
        div_we = 1'b0;
    endtask

    task automatic clr(input logic [1:0] v);
        clr_we = 1'b1; clr_val = v;
        step(1);
        clr_we = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        bit drop;
        bit seen;
        rst_n = 1'b0; div_we = 1'b0; div_val = '0; cmd_we = 1'b0;
        cmd_code = '0; cmd_addr = '0; cmd_data = '0; ien_we = 1'b0;
        ien_val = '0; clr_we = 1'b0; clr_val = '0;
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk(buf_empty && cmd_done, "R1 empty/done", {buf_empty, cmd_done}, 3);
        chk(!hv_on && !acc_err && !part_erased && run_code == 0, "R1 flags",
            {hv_on, acc_err, part_erased}, 0);
        chk(!irq_empty && !irq_done, "R1 irq", {irq_empty, irq_done}, 0);

        // R2 command before divider written
        put(3'd1, 16'h0010, 16'h1111);
        chk(acc_err == 1'b1, "R2 err", acc_err, 1);
        chk(buf_empty && cmd_done, "R2 discarded", {buf_empty, cmd_done}, 3);
        step(3);
        chk(run_code == 0, "R2 nothing runs", run_code, 0);

        // R13 clear error
        clr(2'b01);
        chk(acc_err == 1'b0, "R13 clear err", acc_err, 0);

        set_div(8'd0);

        // R3 unknown codes
        put(3'd0, 16'h0020, 16'h0);
        chk(acc_err && buf_empty, "R3 code0", {acc_err, buf_empty}, 3);
        clr(2'b01);
        put(3'd6, 16'h0020, 16'h0);
        chk(acc_err && buf_empty, "R3 code6", {acc_err, buf_empty}, 3);
        clr(2'b01);

        // R9 interrupt masking at idle
        chk(!irq_empty && !irq_done, "R9 masked", {irq_empty, irq_done}, 0);
        ien_we = 1'b1; ien_val = 2'b01; step(1); ien_we = 1'b0;
        chk(irq_empty && !irq_done, "R9 empty only", {irq_empty, irq_done}, 2);
        ien_we = 1'b1; ien_val = 2'b10; step(1); ien_we = 1'b0;
        chk(!irq_empty && irq_done, "R9 done only", {irq_empty, irq_done}, 1);
        ien_we = 1'b1; ien_val = 2'b11; step(1); ien_we = 1'b0;

        // R6 R14 R10 table of single commands
        for (int v = 0; v < NV; v++) begin
            logic [2:0]  vc;
            logic [15:0] va, vd, vl;
            {vc, va, vd, vl} = VEC[v];
            put(vc, va, vd);
            chk(!buf_empty && !cmd_done, "R4 held", {buf_empty, cmd_done}, 0);
            n = 0;
            while (!cmd_done && n < 3000) begin
                @(posedge clk); n++; @(negedge clk);
                if (n == 1) begin
                    chk(run_code == vc && run_addr == va && run_data == vd,
                        "R14 run fields", run_addr, va);
                    chk(hv_on == (vc == 3'd1 || vc == 3'd2), "R10 hv level",
                        hv_on, (vc == 3'd1 || vc == 3'd2));
                    chk(irq_empty && !irq_done, "R9 running irq",
                        {irq_empty, irq_done}, 2);
                end
            end
            chk(n == int'(vl), "R6 latency", n, vl);
            chk(run_code == 0 && !hv_on, "R8 idle after", run_code, 0);
        end

        // R4 R5 R11 same-row chaining with a rejected third write
        put(3'd1, 16'h0010, 16'hAAAA);
        step(1);
        put(3'd1, 16'h0013, 16'hBBBB);
        chk(!buf_empty, "R4 second queued", buf_empty, 0);
        put(3'd3, 16'h0777, 16'h0);
        chk(acc_err == 1'b1, "R5 full err", acc_err, 1);
        chk(run_addr == 16'h0010 && run_code == 3'd1, "R5 undisturbed",
            run_addr, 16'h0010);
        n = 0; drop = 1'b0; seen = 1'b0;
        while (!cmd_done && n < 300) begin
            @(posedge clk); n++; @(negedge clk);
            if (!cmd_done && !hv_on) drop = 1'b1;
            if (run_addr == 16'h0777 && run_code != 0) seen = 1'b1;
        end
        chk(!drop, "R11 hv held", drop, 0);
        chk(n == 43, "R11 no ramp", n, 43);
        chk(!seen, "R5 dropped cmd never ran", seen, 0);
        clr(2'b01);

        // R10 different rows drop high voltage
        put(3'd1, 16'h0010, 16'h1);
        step(1);
        put(3'd1, 16'h0100, 16'h2);
        n = 0; drop = 1'b0;
        while (!cmd_done && n < 300) begin
            @(posedge clk); n++; @(negedge clk);
            if (!cmd_done && !hv_on) drop = 1'b1;
        end
        chk(drop, "R10 hv drops between rows", drop, 1);

        // R12 abort with nothing running
        put(3'd4, 16'h0, 16'h0);
        chk(!acc_err && !part_erased && cmd_done, "R12 idle abort",
            {acc_err, part_erased, cmd_done}, 1);

        // R12 abort a running erase with a queued verify
        put(3'd2, 16'h0400, 16'h0);
        step(1);
        put(3'd3, 16'h0500, 16'h0);
        chk(!buf_empty, "R12 verify queued", buf_empty, 0);
        step(10);
        put(3'd4, 16'h0, 16'h0);
        chk(buf_empty && !acc_err, "R12 flush", {buf_empty, acc_err}, 2);
        step(1);
        chk(cmd_done && part_erased && !hv_on, "R12 ended",
            {cmd_done, part_erased, hv_on}, 6);
        seen = 1'b0;
        for (int i = 0; i < 60; i++) begin
            step(1);
            if (run_code != 0) seen = 1'b1;
        end
        chk(!seen, "R12 queued verify cleared", seen, 0);

        // R13 selective clear
        put(3'd7, 16'h0, 16'h0);
        clr(2'b01);
        chk(!acc_err && part_erased, "R13 bit0 only", {acc_err, part_erased}, 1);
        clr(2'b10);
        chk(!part_erased, "R13 bit1", part_erased, 0);

        // R7 divider of 3
        set_div(8'd3);
        put(3'd1, 16'h0800, 16'h0);
        n = 0;
        while (!cmd_done && n < 500) begin
            @(posedge clk); n++; @(negedge clk);
        end
        chk(n >= 97 && n <= 105, "R7 tick period", n, 101);
        set_div(8'd0);

        // R1 reset during an erase
        put(3'd2, 16'h0400, 16'h0);
        step(1);
        put(3'd3, 16'h0500, 16'h0);
        step(5);
        do_reset();
        chk(!hv_on && buf_empty && cmd_done && run_code == 0, "R1 mid-op reset",
            {hv_on, buf_empty, cmd_done}, 3);
        put(3'd1, 16'h0010, 16'h0);
        chk(acc_err, "R1 divider unwritten after reset", acc_err, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule